// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block adds eight active-low external interrupt sources to a small processor core and decides which one the core should service next. Each source is filtered through a short synchronizer and then sampled once per machine cycle, on a strobe supplied by the core. A per-source mode bit chooses between falling-edge detection, which latches a pending flag, and low-level detection, where the flag simply follows the pin on every machine cycle.

Sources 0 to 6 each carry a programmable low or high priority. Source 7 always sits on a third, top level that can interrupt any service routine in progress. The controller keeps one in-service marker per level. Acknowledge pulses from the core push the granted level, and return-from-interrupt pulses pop the highest active level. A new request is raised only when its level is strictly above every level already in service.

Software programs the block through a small register bus with three registers: one priority register and two control registers, each holding the mode bit and the flag for four sources.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, the priority register and both control registers read 0x00 and `req_valid` is 0.
- R2: The priority register is at address 0. Bit k (k = 0..6) set to 1 makes source k high priority, and 0 makes it low priority. Bit 7 always reads 0.
- R3: Address 1 holds sources 0..3 and address 2 holds sources 4..7. Source j of a register uses bit 2j as its mode bit (1 = falling edge, 0 = low level) and bit 2j+1 as its pending flag.
- R4: Pins pass through two flops. Flags change only on a cycle with `mc_tick` high, a register write, or an acknowledge.
- R5: In edge mode, the flag is set when the synchronized pin is high at one `mc_tick` and low at the next. The flag is cleared when that source is acknowledged. A pin held low does not set it again.
- R6: In level mode, each `mc_tick` rewrites the flag to 1 if the pin is low and to 0 if it is high. An acknowledge leaves it unchanged.
- R7: A software write to a flag takes effect. If an edge is detected in the same cycle as the write, the hardware set wins.
- R8: Source 7 is on level 2. Other sources are on level 1 (high) or level 0 (low). A pending source is requested only if its level is strictly above the highest level in service.
- R9: Among eligible pending sources, the highest level wins. On a tie, the lowest source index wins. `req_idx` gives the source number 0..7 (source k is external input k+2).
- R10: An acknowledge while `req_valid` is high marks the requested level in service. A `reti` clears the highest in-service level, so lower requests resume only after every higher service has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| mc_tick | input | 1 | Machine-cycle sample strobe |
| ack | input | 1 | Core enters the requested service routine |
| reti | input | 1 | Core returns from the current service routine |
| irq_n | input | 8 | Active-low interrupt pins, bit k is source k |
| req_valid | output | 1 | An eligible request is pending |
| req_idx | output | 3 | Index of the winning source |

## Verification
The properties assume a well-behaved core. `ack` is raised only while `req_valid` is high, `reti` only while some level is in service, and the two never occur in the same cycle. The edge-flag property also assumes no register write coincides with the acknowledge. The stimulus honours these rules: every acknowledge follows a check that a request is present, and every `reti` matches an earlier acknowledge. The pins only change several clocks before a sample strobe, so each strobe sees a settled synchronizer output.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam int unsigned NUM_LVL = 3;
   localparam int unsigned LVL_W   = 2;

   typedef enum logic [LVL_W-1:0] {
      LVL_LOW  = 2'd0,
      LVL_HIGH = 2'd1,
      LVL_TOP  = 2'd2
   } lvl_e;
endpackage

// File: rtl/nic_sync.sv
module nic_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nic_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nic_src.sv
module nic_src (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic tick,
   input  logic edge_mode,
   input  logic sw_we,
   input  logic sw_flag,
   input  logic ack_hit,
   output logic flag_q
);
   logic prev_q;
   logic fall;
   logic flag_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= 1'b1;
      else if (tick) prev_q <= pin_s;
   end

   assign fall = tick & prev_q & ~pin_s;

   always_comb begin
      flag_d = flag_q;
      if (sw_we)                 flag_d = sw_flag;
      if (ack_hit && edge_mode)  flag_d = 1'b0;
      if (tick) begin
         if (!edge_mode) flag_d = ~pin_s;
         else if (fall)  flag_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
   import nic_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]   pend,
   input  lvl_e               src_lvl [N_SRC],
   input  logic [NUM_LVL-1:0] isr,
   output logic               valid,
   output logic [IDX_W-1:0]   idx,
   output lvl_e               win_lvl
);
   logic [NUM_LVL-1:0] blocked;
   logic [N_SRC-1:0]   elig;

   for (genvar l = 0; l < NUM_LVL; l++) begin : g_block
      assign blocked[l] = |isr[NUM_LVL-1:l];
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      assign elig[i] = pend[i] & ~blocked[src_lvl[i]];
   end

   always_comb begin
      valid   = 1'b0;
      idx     = '0;
      win_lvl = LVL_LOW;
      for (int l = NUM_LVL - 1; l >= 0; l--) begin
         for (int i = 0; i < N_SRC; i++) begin
            if (!valid && elig[i] && (int'(src_lvl[i]) == l)) begin
               valid   = 1'b1;
               idx     = IDX_W'(i);
               win_lvl = src_lvl[i];
            end
         end
      end
   end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
   import nic_pkg::*;
#(
   parameter int unsigned N_SRC       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDX_W       = $clog2(N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              mc_tick,
   input  logic              ack,
   input  logic              reti,
   input  logic [N_SRC-1:0]  irq_n,
   output logic              req_valid,
   output logic [IDX_W-1:0]  req_idx
);
   localparam int unsigned SRC_PER_REG = DATA_W / 2;
   localparam int unsigned N_CTRL      = N_SRC / SRC_PER_REG;
   localparam int unsigned N_PRIO      = N_SRC - 1;
   localparam int unsigned TOP_SRC     = N_SRC - 1;

   if (N_SRC % SRC_PER_REG != 0) begin : g_bad_pack
      $error("nested_irq_ctrl: N_SRC must fill whole control registers");
   end
   if (N_PRIO >= DATA_W) begin : g_bad_prio
      $error("nested_irq_ctrl: priority bits must leave the top bit unused");
   end
   if ((1 << ADDR_W) < N_CTRL + 1) begin : g_bad_addr
      $error("nested_irq_ctrl: ADDR_W too small for the register set");
   end

   logic [N_PRIO-1:0]  prio_q;
   logic [N_SRC-1:0]   type_q;
   logic [N_SRC-1:0]   flag_q;
   logic [N_SRC-1:0]   pin_s;
   logic [N_SRC-1:0]   sw_we;
   logic [N_SRC-1:0]   ack_hit;
   logic [NUM_LVL-1:0] isr_q;
   logic [NUM_LVL-1:0] isr_d;
   lvl_e               src_lvl [N_SRC];
   lvl_e               win_lvl;
   logic               prio_we;

   assign prio_we = bus_we && (bus_addr == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prio_q <= '0;
      else if (prio_we) prio_q <= bus_wdata[N_PRIO-1:0];
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam int unsigned REG_SEL = i / SRC_PER_REG + 1;
      localparam int unsigned SLOT    = i % SRC_PER_REG;

      assign sw_we[i]   = bus_we && (bus_addr == ADDR_W'(REG_SEL));
      assign ack_hit[i] = ack && req_valid && (req_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        type_q[i] <= 1'b0;
         else if (sw_we[i]) type_q[i] <= bus_wdata[2*SLOT];
      end

      nic_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (irq_n[i]),
         .q     (pin_s[i])
      );

      nic_src u_src (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_s     (pin_s[i]),
         .tick      (mc_tick),
         .edge_mode (type_q[i]),
         .sw_we     (sw_we[i]),
         .sw_flag   (bus_wdata[2*SLOT+1]),
         .ack_hit   (ack_hit[i]),
         .flag_q    (flag_q[i])
      );

      if (i == TOP_SRC) begin : g_top_lvl
         assign src_lvl[i] = LVL_TOP;
      end else begin : g_prog_lvl
         assign src_lvl[i] = prio_q[i] ? LVL_HIGH : LVL_LOW;
      end
   end

   nic_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
      .pend    (flag_q),
      .src_lvl (src_lvl),
      .isr     (isr_q),
      .valid   (req_valid),
      .idx     (req_idx),
      .win_lvl (win_lvl)
   );

   always_comb begin
      isr_d = isr_q;
      if (reti) begin
         for (int l = 0; l < NUM_LVL; l++) begin
            if (isr_q[l] && ((isr_q >> (l + 1)) == '0)) isr_d[l] = 1'b0;
         end
      end
      if (ack && req_valid) isr_d[win_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) begin
         bus_rdata = DATA_W'(prio_q);
      end else begin
         for (int r = 0; r < N_CTRL; r++) begin
            if (bus_addr == ADDR_W'(r + 1)) begin
               for (int j = 0; j < SRC_PER_REG; j++) begin
                  bus_rdata[2*j]   = type_q[r*SRC_PER_REG + j];
                  bus_rdata[2*j+1] = flag_q[r*SRC_PER_REG + j];
               end
            end
         end
      end
   end
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_we,
   input logic              mc_tick,
   input logic              ack,
   input logic              reti,
   input logic              req_valid,
   input logic [IDX_W-1:0]  req_idx,
   input logic [N_SRC-2:0]  prio_q,
   input logic [N_SRC-1:0]  type_q,
   input logic [N_SRC-1:0]  flag_q,
   input logic [2:0]        isr_q
);
   logic [N_SRC-1:0] prio_ext;
   logic [1:0]       req_lvl;

   assign prio_ext = {1'b0, prio_q};
   assign req_lvl  = (req_idx == IDX_W'(N_SRC - 1)) ? 2'd2 :
                     (prio_ext[req_idx] ? 2'd1 : 2'd0);

   a_r2_prio_msb_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == '0) |-> (bus_rdata[DATA_W-1] == 1'b0));

   a_r4_flags_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!mc_tick && !bus_we && !ack) |=> $stable(flag_q));

   a_r5_edge_ack_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req_valid && type_q[req_idx] && !mc_tick && !bus_we)
      |=> (flag_q[$past(req_idx)] == 1'b0));

   a_r8_strictly_above : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((isr_q >> req_lvl) == 3'b000));

   a_r10_push : assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req_valid && !reti)
      |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

   a_r10_pop : assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !ack && (isr_q != 3'b000))
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

bind nested_irq_ctrl nic_chk #(
   .N_SRC  (N_SRC),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_nic_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .bus_we    (bus_we),
   .mc_tick   (mc_tick),
   .ack       (ack),
   .reti      (reti),
   .req_valid (req_valid),
   .req_idx   (req_idx),
   .prio_q    (prio_q),
   .type_q    (type_q),
   .flag_q    (flag_q),
   .isr_q     (isr_q)
);

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic       mc_tick = 1'b0;
   logic       ack = 1'b0;
   logic       reti = 1'b0;
   logic [7:0] irq_n = 8'hFF;
   logic       req_valid;
   logic [2:0] req_idx;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      bit         is_reg;
      logic [7:0] exp_data;
      bit         exp_valid;
      logic [2:0] exp_idx;
      string      tag;
   } item_t;

   item_t sb_q[$];

   always #10 clk = ~clk;

   nested_irq_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .mc_tick   (mc_tick),
      .ack       (ack),
      .reti      (reti),
      .irq_n     (irq_n),
      .req_valid (req_valid),
      .req_idx   (req_idx)
   );

   // monitor: pops expected items and compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (it.is_reg) begin
               if (bus_rdata !== it.exp_data) begin
                  n_fail++;
                  $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.exp_data);
               end
            end else if (req_valid !== it.exp_valid ||
                         (it.exp_valid && req_idx !== it.exp_idx)) begin
               n_fail++;
               $display("FAIL %s: valid=%b idx=%0d expected valid=%b idx=%0d",
                        it.tag, req_valid, req_idx, it.exp_valid, it.exp_idx);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic settle();
      repeat (3) step();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      step();
      bus_we = 1'b0;
   endtask

   task automatic tick();
      mc_tick = 1'b1;
      step();
      mc_tick = 1'b0;
   endtask

   task automatic do_ack();
      ack = 1'b1;
      step();
      ack = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1;
      step();
      reti = 1'b0;
   endtask

   task automatic exp_reg(input logic [1:0] a, input logic [7:0] d, input string tag);
      item_t it;
      bus_addr = a;
      it.is_reg = 1'b1; it.exp_data = d; it.exp_valid = 1'b0; it.exp_idx = '0; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic exp_req(input bit v, input logic [2:0] idx, input string tag);
      item_t it;
      it.is_reg = 1'b0; it.exp_data = '0; it.exp_valid = v; it.exp_idx = idx; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_n = 8'hFF; bus_we = 1'b0; mc_tick = 1'b0; ack = 1'b0; reti = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run incomplete, expected completion");
         finish_run();
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      exp_reg(2'd0, 8'h00, "R1 prio reset");
      exp_reg(2'd1, 8'h00, "R1 ctrlA reset");
      exp_reg(2'd2, 8'h00, "R1 ctrlB reset");
      exp_req(1'b0, 3'd0, "R1 no request");

      // R2 priority register, top bit unused
      wr(2'd0, 8'hFF);
      exp_reg(2'd0, 8'h7F, "R2 bit7 reads zero");

      // R3/R4/R5 edge mode on source 0 (type bit0, flag bit1)
      do_reset();
      wr(2'd1, 8'h01);
      exp_reg(2'd1, 8'h01, "R3 type bit written");
      irq_n[0] = 1'b0;
      settle();
      exp_reg(2'd1, 8'h01, "R4 no sample without tick");
      tick();
      exp_reg(2'd1, 8'h03, "R5 falling edge sets flag");
      exp_req(1'b1, 3'd0, "R9 source0 requested");
      do_ack();
      exp_reg(2'd1, 8'h01, "R5 ack clears edge flag");
      exp_req(1'b0, 3'd0, "R10 in service blocks");
      tick();
      exp_reg(2'd1, 8'h01, "R5 held low no re-set");
      do_reti();
      exp_req(1'b0, 3'd0, "R10 pop with no flag");
      irq_n[0] = 1'b1; settle(); tick();
      irq_n[0] = 1'b0; settle(); tick();
      exp_reg(2'd1, 8'h03, "R5 second edge sets flag");

      // R7 software flag writes, hardware set wins
      do_reset();
      wr(2'd1, 8'h01);
      irq_n[0] = 1'b0;
      settle();
      bus_addr = 2'd1; bus_wdata = 8'h01; bus_we = 1'b1; mc_tick = 1'b1;
      step();
      bus_we = 1'b0; mc_tick = 1'b0;
      exp_reg(2'd1, 8'h03, "R7 hardware set beats write");
      wr(2'd1, 8'h01);
      exp_reg(2'd1, 8'h01, "R7 software clear");
      wr(2'd1, 8'h03);
      exp_reg(2'd1, 8'h03, "R7 software set");

      // R6 level mode on source 1 (flag bit3)
      do_reset();
      irq_n[1] = 1'b0;
      settle(); tick();
      exp_reg(2'd1, 8'h08, "R6 level flag follows low pin");
      exp_req(1'b1, 3'd1, "R6 level request");
      do_ack();
      exp_reg(2'd1, 8'h08, "R6 ack keeps level flag");
      exp_req(1'b0, 3'd0, "R8 same level waits");
      do_reti();
      exp_req(1'b1, 3'd1, "R10 request resumes after reti");
      irq_n[1] = 1'b1;
      settle(); tick();
      exp_reg(2'd1, 8'h00, "R6 level flag follows high pin");
      exp_req(1'b0, 3'd0, "R6 request gone");

      // R8/R10 nesting across three levels
      do_reset();
      wr(2'd0, 8'h08);
      exp_reg(2'd0, 8'h08, "R2 source3 high");
      irq_n[2] = 1'b0; irq_n[3] = 1'b0;
      settle(); tick();
      exp_req(1'b1, 3'd3, "R9 high level beats lower index");
      do_ack();
      exp_req(1'b0, 3'd0, "R8 low cannot preempt high");
      irq_n[7] = 1'b0;
      settle(); tick();
      exp_reg(2'd2, 8'h80, "R3 source7 flag at B bit7");
      exp_req(1'b1, 3'd7, "R8 top level preempts high");
      do_ack();
      exp_req(1'b0, 3'd0, "R10 all blocked at top");
      irq_n[7] = 1'b1;
      settle(); tick();
      do_reti();
      exp_req(1'b0, 3'd0, "R10 high still in service");
      do_reti();
      exp_req(1'b1, 3'd3, "R10 pops to empty");

      // R9 ties resolve to lowest index
      do_reset();
      wr(2'd0, 8'h30);
      irq_n[2] = 1'b0; irq_n[4] = 1'b0; irq_n[5] = 1'b0;
      settle(); tick();
      exp_reg(2'd2, 8'h0A, "R3 B flags for sources 4 and 5");
      exp_req(1'b1, 3'd4, "R9 tie lowest index");
      irq_n[4] = 1'b1;
      settle(); tick();
      exp_req(1'b1, 3'd5, "R9 next high source");
      wr(2'd0, 8'h00);
      exp_req(1'b1, 3'd2, "R9 all low lowest index");

      // R8 top level preempts a low service
      do_reset();
      irq_n[2] = 1'b0;
      settle(); tick();
      do_ack();
      irq_n[7] = 1'b0;
      settle(); tick();
      exp_req(1'b1, 3'd7, "R8 top preempts low");

      done = 1'b1;
      finish_run();
   end
endmodule